// File: doc/BRIEF.md
# Multi-Cycle XOR Sprite Draw Engine

This block performs the sprite-draw step of a small 8-bit interpreter core. It takes one sprite of up to fifteen rows, each row one byte wide, from a byte-wide memory. It toggles the sprite's pixels onto a one-bit-per-pixel framebuffer with XOR, so drawing the same sprite twice erases it. It also reports whether any lit pixel was turned off along the way. The framebuffer storage and any copy of it for display live outside the block. The engine only produces the address, read and write strobes for it.

The engine keeps no sequencing state of its own. An external stage counter advances once per cycle during an execute window. The engine subtracts a fixed start offset from it and slices the result into fields. The low bits are a settle phase, the next bits give the pixel column inside the row, and the upper bits count the rows already finished. Each pixel gets a full settle phase, so the memory and framebuffer read data can arrive before the write fires in the last cycle of the phase. The collision flag is the only register. It is the value the surrounding core places in its flag register after the draw.

Top module: `sprite_draw_engine`

## Requirements
- R1: The engine is busy only while `exec_i` is high, `instr_i[15:12]` equals 4'hD, `stage_i` is at least 16, and the rows-finished count is below n = `instr_i[3:0]`. `mem_req_o` follows busy, and no framebuffer write happens when not busy.
- R2: With offset stage k = `stage_i` - 16, the column c = k[6:4], and `fb_x_o` = (Vx + c) mod 64.
- R3: The rows-finished count is r = k >> 7, the row index is r[3:0], and `fb_y_o` = (Vy + r[3:0]) mod 32.
- R4: `mem_addr_o` = (I + r) mod 4096 while busy.
- R5: The pixel drawn at column c is bit (7 - c) of `mem_rdata_i`, so the most significant bit is the leftmost pixel.
- R6: `fb_wdata_o` equals the selected sprite bit XOR `fb_rdata_i`.
- R7: `fb_we_o` is high only while busy and only when `stage_i[3:0]` is 4'hF, so exactly one write happens per pixel.
- R8: `hit_o` resets to 0 and is cleared when `stage_i` equals 16 at the start of a draw. It is set after any write whose sprite bit and existing pixel are both 1, and it otherwise holds its value.
- R9: A draw with n = 0 issues no memory request and no framebuffer write, and leaves `hit_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute window of the current instruction is open |
| instr_i | input | 16 | Current instruction word |
| vx_i | input | 8 | Value of the register selected by instr_i[11:8] |
| vy_i | input | 8 | Value of the register selected by instr_i[7:4] |
| idx_i | input | 12 | Index register, start address of the sprite |
| stage_i | input | 32 | Stage counter of the execute window |
| mem_rdata_i | input | 8 | Sprite byte read from memory |
| fb_rdata_i | input | 1 | Current framebuffer pixel at fb_x_o/fb_y_o |
| vx_sel_o | output | 4 | Register-file read select for the x origin |
| vy_sel_o | output | 4 | Register-file read select for the y origin |
| mem_addr_o | output | 12 | Sprite byte address |
| mem_req_o | output | 1 | Memory read request |
| fb_x_o | output | 6 | Framebuffer column |
| fb_y_o | output | 5 | Framebuffer row |
| fb_wdata_o | output | 1 | Pixel value to write |
| fb_we_o | output | 1 | Framebuffer write enable |
| busy_o | output | 1 | Draw in progress |
| hit_o | output | 1 | Collision flag of the latest draw |

## Verification
The assertions assume that the stage counter rises by one per cycle from zero inside an execute window. They also assume that the stage counter passes 16 exactly once per draw, and that memory and framebuffer reads answer within the settle phase. Without these, the clear-at-start and sticky-collision properties lose their meaning. The bench drives the stage counter itself in exactly that way. It models memory and framebuffer as combinational reads that answer in the same cycle, and it keeps the origin registers, index and instruction stable for the whole window. Random origins, indices and row counts are mixed with directed cases: wrap at both screen edges, zero rows, a repeated draw that erases, and a non-draw opcode.

// File: rtl/spr_pkg.sv
package spr_pkg;

   localparam logic [3:0] OPC_DRAW = 4'hD;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/spr_stage_dec.sv
module spr_stage_dec #(
   parameter int STAGE_W  = 32,
   parameter int OFFSET   = 16,
   parameter int SETTLE_W = 4,
   parameter int XO_W     = 3,
   parameter int ROW_W    = 4,
   localparam int CNT_W   = STAGE_W - SETTLE_W - XO_W
) (
   input  logic [STAGE_W-1:0] stage_i,
   input  logic               exec_i,
   input  logic               is_draw_i,
   input  logic [ROW_W-1:0]   n_i,
   output logic               in_win_o,
   output logic               start_o,
   output logic               settle_o,
   output logic               busy_o,
   output logic [XO_W-1:0]    xo_o,
   output logic [CNT_W-1:0]   rows_o,
   output logic [ROW_W-1:0]   row_o
);

   logic [STAGE_W-1:0] off;

   assign off      = stage_i - STAGE_W'(OFFSET);
   assign in_win_o = exec_i & is_draw_i & (stage_i >= STAGE_W'(OFFSET));
   assign start_o  = in_win_o & (off == '0);
   assign settle_o = &off[SETTLE_W-1:0];
   assign xo_o     = off[SETTLE_W +: XO_W];
   assign rows_o   = off[STAGE_W-1 -: CNT_W];
   assign row_o    = rows_o[ROW_W-1:0];
   assign busy_o   = in_win_o & (rows_o < CNT_W'(n_i));

endmodule

// File: rtl/spr_coord.sv
module spr_coord #(
   parameter int REG_W = 8,
   parameter int XO_W  = 3,
   parameter int ROW_W = 4,
   parameter int FB_W  = 64,
   parameter int FB_H  = 32,
   parameter bit WRAP  = 1'b1,
   localparam int FBX_W = $clog2(FB_W),
   localparam int FBY_W = $clog2(FB_H)
) (
   input  logic [REG_W-1:0] vx_i,
   input  logic [REG_W-1:0] vy_i,
   input  logic [XO_W-1:0]  xo_i,
   input  logic [ROW_W-1:0] row_i,
   output logic [FBX_W-1:0] x_o,
   output logic [FBY_W-1:0] y_o,
   output logic             on_screen_o
);

   logic [REG_W:0] sum_x;
   logic [REG_W:0] sum_y;

   assign sum_x = {1'b0, vx_i} + (REG_W + 1)'(xo_i);
   assign sum_y = {1'b0, vy_i} + (REG_W + 1)'(row_i);
   assign x_o   = sum_x[FBX_W-1:0];
   assign y_o   = sum_y[FBY_W-1:0];

   generate
      if (WRAP) begin : g_wrap
         logic unused_hi;
         assign unused_hi   = ^{sum_x[REG_W:FBX_W], sum_y[REG_W:FBY_W]};
         assign on_screen_o = 1'b1;
      end else begin : g_clip
         assign on_screen_o = (sum_x < (REG_W + 1)'(FB_W)) &&
                              (sum_y < (REG_W + 1)'(FB_H));
      end
   endgenerate

endmodule

// File: rtl/spr_pixel.sv
module spr_pixel #(
   parameter int SPR_W = 8,
   localparam int XO_W = $clog2(SPR_W)
) (
   input  logic [SPR_W-1:0] spr_i,
   input  logic [XO_W-1:0]  xo_i,
   input  logic             pix_i,
   input  logic             fire_i,
   output logic             wdata_o,
   output logic             we_o,
   output logic             hit_evt_o
);

   localparam logic [XO_W-1:0] MSB_IDX = XO_W'(SPR_W - 1);

   logic [XO_W-1:0] sel;
   logic            spr_bit;

   assign sel       = MSB_IDX - xo_i;
   assign spr_bit   = spr_i[sel];
   assign wdata_o   = spr_bit ^ pix_i;
   assign we_o      = fire_i;
   assign hit_evt_o = fire_i & spr_bit & pix_i;

endmodule

// File: rtl/spr_collide.sv
module spr_collide (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic hit_evt_i,
   output logic hit_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        hit_o <= 1'b0;
      else if (start_i)   hit_o <= 1'b0;
      else if (hit_evt_i) hit_o <= 1'b1;
   end

   // R8: a new draw starts with a clean flag
   p_start_clears_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> !hit_o);

   // R8: once set, the flag holds until the next draw starts
   p_hit_sticky_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o && !start_i) |=> hit_o);

endmodule

// File: rtl/sprite_draw_engine.sv
module sprite_draw_engine #(
   parameter int ADDR_W   = 12,
   parameter int STAGE_W  = 32,
   parameter int REG_W    = 8,
   parameter int SPR_W    = 8,
   parameter int FB_W     = 64,
   parameter int FB_H     = 32,
   parameter int SETTLE_W = 4,
   parameter int OFFSET   = 16,
   parameter bit WRAP     = 1'b1,
   localparam int INSTR_W = 16,
   localparam int ROW_W   = 4,
   localparam int SEL_W   = 4,
   localparam int XO_W    = $clog2(SPR_W),
   localparam int FBX_W   = $clog2(FB_W),
   localparam int FBY_W   = $clog2(FB_H),
   localparam int CNT_W   = STAGE_W - SETTLE_W - XO_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               exec_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [REG_W-1:0]   vx_i,
   input  logic [REG_W-1:0]   vy_i,
   input  logic [ADDR_W-1:0]  idx_i,
   input  logic [STAGE_W-1:0] stage_i,
   input  logic [SPR_W-1:0]   mem_rdata_i,
   input  logic               fb_rdata_i,
   output logic [SEL_W-1:0]   vx_sel_o,
   output logic [SEL_W-1:0]   vy_sel_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   output logic               mem_req_o,
   output logic [FBX_W-1:0]   fb_x_o,
   output logic [FBY_W-1:0]   fb_y_o,
   output logic               fb_wdata_o,
   output logic               fb_we_o,
   output logic               busy_o,
   output logic               hit_o
);

   import spr_pkg::*;

   generate
      if (!is_pow2(SPR_W))            begin : g_bad_spr  $error("SPR_W must be a power of two");   end
      if (!is_pow2(FB_W))             begin : g_bad_fbw  $error("FB_W must be a power of two");    end
      if (!is_pow2(FB_H))             begin : g_bad_fbh  $error("FB_H must be a power of two");    end
      if (FBX_W > REG_W || FBY_W > REG_W) begin : g_bad_reg $error("screen wider than registers"); end
      if ((OFFSET % (1 << SETTLE_W)) != 0) begin : g_bad_off $error("OFFSET must align to the settle phase"); end
      if (CNT_W < ROW_W)              begin : g_bad_cnt  $error("STAGE_W too small");             end
   endgenerate

   logic             in_win, start, settle, busy, on_screen, fire, hit_evt;
   logic [XO_W-1:0]  xo;
   logic [CNT_W-1:0] rows;
   logic [ROW_W-1:0] row;

   assign vx_sel_o = instr_i[11:8];
   assign vy_sel_o = instr_i[7:4];

   spr_stage_dec #(
      .STAGE_W (STAGE_W), .OFFSET (OFFSET), .SETTLE_W (SETTLE_W),
      .XO_W (XO_W), .ROW_W (ROW_W)
   ) i_dec (
      .stage_i   (stage_i),
      .exec_i    (exec_i),
      .is_draw_i (instr_i[15:12] == OPC_DRAW),
      .n_i       (instr_i[3:0]),
      .in_win_o  (in_win),
      .start_o   (start),
      .settle_o  (settle),
      .busy_o    (busy),
      .xo_o      (xo),
      .rows_o    (rows),
      .row_o     (row)
   );

   spr_coord #(
      .REG_W (REG_W), .XO_W (XO_W), .ROW_W (ROW_W),
      .FB_W (FB_W), .FB_H (FB_H), .WRAP (WRAP)
   ) i_coord (
      .vx_i        (vx_i),
      .vy_i        (vy_i),
      .xo_i        (xo),
      .row_i       (row),
      .x_o         (fb_x_o),
      .y_o         (fb_y_o),
      .on_screen_o (on_screen)
   );

   assign fire = busy & settle & on_screen;

   spr_pixel #(.SPR_W (SPR_W)) i_pix (
      .spr_i     (mem_rdata_i),
      .xo_i      (xo),
      .pix_i     (fb_rdata_i),
      .fire_i    (fire),
      .wdata_o   (fb_wdata_o),
      .we_o      (fb_we_o),
      .hit_evt_o (hit_evt)
   );

   spr_collide i_col (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .hit_evt_i (hit_evt),
      .hit_o     (hit_o)
   );

   assign mem_addr_o = idx_i + ADDR_W'(rows);
   assign mem_req_o  = busy;
   assign busy_o     = busy;

   logic unused_win;
   assign unused_win = in_win;

   // R1: nothing moves outside the execute window
   p_idle_quiet_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !exec_i |-> (!mem_req_o && !fb_we_o && !busy_o));

   // R7: a write only in the last cycle of a settle phase
   p_we_settled_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fb_we_o |-> (&stage_i[SETTLE_W-1:0]));

   // R7: a write only inside the row budget
   p_we_in_rows_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fb_we_o |-> (busy_o && mem_req_o));

   // R8: turning a lit pixel off raises the flag on the next cycle
   p_overlap_sets_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fb_we_o && fb_rdata_i && !fb_wdata_o) |=> hit_o);

endmodule

// File: tb/test_sprite_draw_engine.sv
module test_sprite_draw_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec = 1'b0;
   logic [15:0] instr = '0;
   logic [7:0]  vx = '0, vy = '0;
   logic [11:0] idx = '0;
   logic [31:0] stage = '0;
   logic [7:0]  mem_rdata;
   logic        fb_rdata;
   logic [3:0]  vx_sel, vy_sel;
   logic [11:0] mem_addr;
   logic        mem_req, fb_wdata, fb_we, busy, hit;
   logic [5:0]  fb_x;
   logic [4:0]  fb_y;

   logic [7:0] mem    [4096];
   logic       fb_mem [2048];
   logic       ref_fb [2048];
   bit         exp_hit;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   sprite_draw_engine i_sprite_draw_engine (
      .clk_i (clk), .rst_ni (rst_n), .exec_i (exec), .instr_i (instr),
      .vx_i (vx), .vy_i (vy), .idx_i (idx), .stage_i (stage),
      .mem_rdata_i (mem_rdata), .fb_rdata_i (fb_rdata),
      .vx_sel_o (vx_sel), .vy_sel_o (vy_sel),
      .mem_addr_o (mem_addr), .mem_req_o (mem_req),
      .fb_x_o (fb_x), .fb_y_o (fb_y), .fb_wdata_o (fb_wdata),
      .fb_we_o (fb_we), .busy_o (busy), .hit_o (hit)
   );

   assign mem_rdata = mem[mem_addr];
   assign fb_rdata  = fb_mem[int'(fb_y) * 64 + int'(fb_x)];

   always @(posedge clk) if (fb_we) fb_mem[int'(fb_y) * 64 + int'(fb_x)] <= fb_wdata;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // Independent model of one draw applied to ref_fb
   task automatic ref_draw(input int ox, input int oy, input int base, input int n);
      for (int p = 0; p < 2048; p++) ref_fb[p] = fb_mem[p];
      exp_hit = 1'b0;
      for (int r = 0; r < n; r++) begin
         for (int c = 0; c < 8; c++) begin
            int px = (ox + c) % 64;
            int py = (oy + r) % 32;
            bit b  = mem[(base + r) % 4096][7 - c];
            if (b && ref_fb[py * 64 + px]) exp_hit = 1'b1;
            ref_fb[py * 64 + px] = ref_fb[py * 64 + px] ^ b;
         end
      end
   endtask

   task automatic run_draw(input logic [3:0] opc, input int ox, input int oy,
                           input int base, input int n);
      int  last = 16 + n * 128 + 40;
      bit  isd  = (opc == 4'hD);
      int  mism = 0;
      bit  pre_hit;
      @(negedge clk);
      pre_hit = hit;
      if (isd) ref_draw(ox, oy, base, n);
      else begin
         for (int p = 0; p < 2048; p++) ref_fb[p] = fb_mem[p];
         exp_hit = pre_hit;
      end
      instr = {opc, 4'h3, 4'h7, 4'(n)};
      vx = 8'(ox); vy = 8'(oy); idx = 12'(base);
      exec = 1'b1;
      for (int s = 0; s <= last; s++) begin
         int off, rows, xo, ea, ex, ey;
         bit eb, ew, eb_bit;
         stage = 32'(s);
         #1;
         off  = s - 16;
         rows = (isd && s >= 16) ? (off >> 7) : 0;
         eb   = isd && s >= 16 && rows < n;
         ew   = eb && ((s & 15) == 15);
         xo   = (off >> 4) & 7;
         ea   = (base + rows) % 4096;
         ex   = (ox + xo) % 64;
         ey   = (oy + (rows & 15)) % 32;
         check(busy == eb && mem_req == eb, "R1", "busy/req", int'(busy), int'(eb));
         check(fb_we == ew, "R7", "write enable", int'(fb_we), int'(ew));
         if (n == 0) check(!fb_we && !mem_req, "R9", "idle on zero rows", int'(fb_we), 0);
         if (eb) begin
            check(int'(mem_addr) == ea, "R4", "sprite address", int'(mem_addr), ea);
            check(int'(fb_x) == ex, "R2", "column", int'(fb_x), ex);
            check(int'(fb_y) == ey, "R3", "row", int'(fb_y), ey);
         end
         if (ew) begin
            eb_bit = mem[ea][7 - xo];
            check(fb_wdata == (eb_bit ^ fb_mem[ey * 64 + ex]), "R5/R6",
                  "pixel xor", int'(fb_wdata), int'(eb_bit ^ fb_mem[ey * 64 + ex]));
         end
         @(negedge clk);
      end
      exec  = 1'b0;
      stage = '0;
      #1;
      for (int p = 0; p < 2048; p++) if (fb_mem[p] !== ref_fb[p]) mism++;
      check(mism == 0, isd ? "R6" : "R1", "framebuffer mismatches", mism, 0);
      check(hit == exp_hit, isd ? "R8" : "R1", "collision flag", int'(hit), int'(exp_hit));
   endtask

   initial begin
      #(200000 * 4);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int a = 0; a < 4096; a++) mem[a] = 8'($urandom);
      for (int p = 0; p < 2048; p++) fb_mem[p] = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(hit == 1'b0, "R8", "reset flag", int'(hit), 0);
      check(!mem_req && !fb_we && !busy, "R1", "reset idle", int'(busy), 0);
      check(vx_sel == 4'h0 && vy_sel == 4'h0, "R1", "register selects", int'(vx_sel), 0);
      rst_n = 1'b1;

      // R2 R3 wrap at the screen corner, full height sprite
      run_draw(4'hD, 62, 30, 4090, 15);
      // R8 the same sprite again erases it and reports a collision
      run_draw(4'hD, 62, 30, 4090, 15);
      check(exp_hit == 1'b1, "R8", "repeat draw collides", int'(hit), 1);
      // R9 zero rows leaves flag cleared
      run_draw(4'hD, 5, 5, 100, 0);
      check(hit == 1'b0, "R9", "zero-row flag", int'(hit), 0);
      // R1 a non-draw opcode does nothing
      run_draw(4'h8, 10, 10, 200, 7);
      // R5 single-bit sprite: only leftmost pixel
      mem[300] = 8'h80;
      run_draw(4'hD, 0, 0, 300, 1);
      check(fb_mem[0] == 1'b1 && fb_mem[1] == 1'b0, "R5", "MSB leftmost",
            int'(fb_mem[1]), 0);
      // constrained random draws
      for (int k = 0; k < 24; k++)
         run_draw(4'hD, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 4095)), int'($urandom_range(0, 15)));
      summary();
   end

endmodule